// File: doc/BRIEF.md
# Pin-Triggered Deep Power-Down Sequencer

This block takes a small processor core into its deepest low-power state when an external, active-low request pin is pulled low. The request is brought into the core clock domain through a short flop chain. It is then looked at only on clock edges that carry the machine-cycle strobe. When the request is seen active, the sequencer first puts the core through a full internal reset that lasts two machine cycles. During that reset the watchdog timer is halted and its status flag is cleared, and power is not yet reduced. After that it turns off the main oscillator enable and the auxiliary RC oscillator enable in the same step, and lets the pads float.

Entering this mode needs the oscillator-watchdog enable pin to be high. With that pin low, a request is not acted on. The software power-save enable pin plays no part at all; it matters only to the modes that software starts. When the request is seen inactive while powered down, both oscillators are switched back on at once. Reset stays applied for a parameterised number of machine cycles while the clocks settle, and is then released.

The real oscillators and pad analog behaviour lie outside the block and appear only as enable and control outputs. The strobe input is a one-clock pulse once per machine cycle.

Top module: `pdseq_top`

## Requirements
- R1: While and after `rst_n` is low, `core_rst`, `wdt_stop`, `wdt_clr`, `pad_float` and `pd_status` are 0 and both `main_osc_en` and `rc_osc_en` are 1.
- R2: `pd_req_n` is active low and passes through `SYNC_STAGES` flops. It is acted on only at a clock edge where `mc_strobe` is 1, so a low pulse that is not present in synchronized form at a strobe edge has no effect.
- R3: When the synchronized request is low and `osc_wd_en` is 1 at a strobe edge, `core_rst`, `wdt_stop` and `wdt_clr` go to 1 after that edge. This reset phase lasts exactly two machine cycles, with the oscillators still enabled.
- R4: At the second strobe edge of the reset phase, `main_osc_en` and `rc_osc_en` fall together, `pad_float` and `pd_status` rise, `wdt_clr` returns to 0, and `core_rst` and `wdt_stop` stay 1.
- R5: With `osc_wd_en` at 0, a low request at strobe edges leaves the block running: `core_rst` stays 0 and the oscillators stay on.
- R6: `sw_save_en` has no effect; entry, power-down and exit behave the same with it at 0 or 1.
- R7: In power-down, a strobe edge with the synchronized request high sets both oscillator enables to 1 and clears `pad_float` and `pd_status`. `core_rst` and `wdt_stop` then stay 1 for `STAB_MC` machine cycles and drop to 0 together.
- R8: Once the reset phase has started, it runs to power-down even if the request goes inactive during it.
- R9: Every output changes only after a clock edge where `mc_strobe` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low |
| mc_strobe | input | 1 | One-clock pulse once per machine cycle |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| osc_wd_en | input | 1 | Oscillator-watchdog enable; must be 1 for this mode |
| sw_save_en | input | 1 | Software power-save enable; not used by this mode |
| core_rst | output | 1 | Internal reset to the core, active high |
| wdt_stop | output | 1 | Halts the watchdog timer |
| wdt_clr | output | 1 | Clears the watchdog status flag (high during the reset phase) |
| main_osc_en | output | 1 | Main oscillator enable |
| rc_osc_en | output | 1 | Auxiliary RC oscillator enable |
| pad_float | output | 1 | Puts port pads and control lines in tristate |
| pd_status | output | 1 | High only while fully powered down |

## Verification
The bench builds the block with `STAB_MC` = 3 and `SYNC_STAGES` = 2, and drives a strobe every four clocks. With these values the reset phase is 8 clocks and the settle phase is 12 clocks, so every phase length is checked to the exact clock. Several full enter and exit cycles fit in a short run. The short chain also lets a single-clock request glitch be placed between two strobes, which shows that sampling happens only once per machine cycle.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_RST  = 2'd1,
    PH_DOWN = 2'd2,
    PH_WAKE = 2'd3
  } pd_phase_t;

  // number of machine cycles the internal reset is held before gating clocks
  localparam int unsigned RESET_MC = 2;
endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
#(
  parameter int unsigned STAB_MC = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe,
  input  logic      req_n_sync,
  input  logic      owd_en,
  output pd_phase_t phase
);
  localparam int unsigned MAXC  = (STAB_MC > RESET_MC) ? STAB_MC : RESET_MC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RESET_MC - 1);
  localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'(STAB_MC - 1);

  pd_phase_t        phase_q, phase_d;
  logic [CNT_W-1:0] mc_cnt_q, mc_cnt_d;
  logic             req_hit;

  assign req_hit = !req_n_sync && owd_en;

  always_comb begin
    phase_d  = phase_q;
    mc_cnt_d = mc_cnt_q;
    if (strobe) begin
      unique case (phase_q)
        PH_RUN: begin
          if (req_hit) begin
            phase_d  = PH_RST;
            mc_cnt_d = '0;
          end
        end
        PH_RST: begin
          if (mc_cnt_q == RST_LAST) begin
            phase_d  = PH_DOWN;
            mc_cnt_d = '0;
          end else begin
            mc_cnt_d = mc_cnt_q + 1'b1;
          end
        end
        PH_DOWN: begin
          if (req_n_sync) begin
            phase_d  = PH_WAKE;
            mc_cnt_d = '0;
          end
        end
        PH_WAKE: begin
          if (mc_cnt_q == STAB_LAST) begin
            phase_d  = PH_RUN;
            mc_cnt_d = '0;
          end else begin
            mc_cnt_d = mc_cnt_q + 1'b1;
          end
        end
        default: phase_d = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_RUN;
      mc_cnt_q <= '0;
    end else begin
      phase_q  <= phase_d;
      mc_cnt_q <= mc_cnt_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/pdseq_outdec.sv
module pdseq_outdec
  import pdseq_pkg::*;
(
  input  pd_phase_t phase,
  output logic      core_rst,
  output logic      wdt_stop,
  output logic      wdt_clr,
  output logic      main_osc_en,
  output logic      rc_osc_en,
  output logic      pad_float,
  output logic      pd_status
);
  always_comb begin
    core_rst    = (phase != PH_RUN);
    wdt_stop    = (phase != PH_RUN);
    wdt_clr     = (phase == PH_RST);
    main_osc_en = (phase != PH_DOWN);
    rc_osc_en   = (phase != PH_DOWN);
    pad_float   = (phase == PH_DOWN);
    pd_status   = (phase == PH_DOWN);
  end
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STAB_MC     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_strobe,
  input  logic pd_req_n,
  input  logic osc_wd_en,
  input  logic sw_save_en,
  output logic core_rst,
  output logic wdt_stop,
  output logic wdt_clr,
  output logic main_osc_en,
  output logic rc_osc_en,
  output logic pad_float,
  output logic pd_status
);
  logic      req_n_sync;
  pd_phase_t phase;
  logic      sw_save_unused;

  // the software power-save gate belongs to other low-power modes only
  assign sw_save_unused = sw_save_en;

  pdseq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pd_req_n),
    .q_sync  (req_n_sync)
  );

  pdseq_ctrl #(.STAB_MC(STAB_MC)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (mc_strobe),
    .req_n_sync (req_n_sync),
    .owd_en     (osc_wd_en),
    .phase      (phase)
  );

  pdseq_outdec i_dec (
    .phase       (phase),
    .core_rst    (core_rst),
    .wdt_stop    (wdt_stop),
    .wdt_clr     (wdt_clr),
    .main_osc_en (main_osc_en),
    .rc_osc_en   (rc_osc_en),
    .pad_float   (pad_float),
    .pd_status   (pd_status)
  );
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk (
  input logic clk,
  input logic rst_n,
  input logic mc_strobe,
  input logic pd_req_n,
  input logic osc_wd_en,
  input logic sw_save_en,
  input logic core_rst,
  input logic wdt_stop,
  input logic wdt_clr,
  input logic main_osc_en,
  input logic rc_osc_en,
  input logic pad_float,
  input logic pd_status
);
  // R3
  rst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> (wdt_clr && wdt_stop && main_osc_en && rc_osc_en));

  // R4
  osc_off_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_osc_en) |-> ($past(wdt_clr) && !rc_osc_en && pad_float));

  // R5
  owd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_strobe && !osc_wd_en && !core_rst) |=> !core_rst);

  // R7
  osc_on_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_osc_en) |-> (core_rst && rc_osc_en && !pd_status));

  // R9
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_strobe |=> $stable({core_rst, wdt_clr, pad_float, main_osc_en}));
endmodule

bind pdseq_top pdseq_chk i_chk (.*);

// File: tb/test_pdseq_top.sv
module test_pdseq_top;
  localparam int unsigned STAB = 3;
  localparam int unsigned MCLK = 4;

  logic clk = 1'b0;
  logic rst_n, mc_strobe, pd_req_n, osc_wd_en, sw_save_en;
  logic core_rst, wdt_stop, wdt_clr, main_osc_en, rc_osc_en, pad_float, pd_status;

  int checks = 0;
  int failures = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  pdseq_top #(.SYNC_STAGES(2), .STAB_MC(STAB)) i_pdseq_top (
    .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe), .pd_req_n(pd_req_n),
    .osc_wd_en(osc_wd_en), .sw_save_en(sw_save_en), .core_rst(core_rst),
    .wdt_stop(wdt_stop), .wdt_clr(wdt_clr), .main_osc_en(main_osc_en),
    .rc_osc_en(rc_osc_en), .pad_float(pad_float), .pd_status(pd_status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // phases: 0 run, 1 reset, 2 down, 3 settle
  function automatic int phase_of();
    if (pd_status) return 2;
    if (!core_rst) return 0;
    if (wdt_clr) return 1;
    return 3;
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // machine-cycle strobe: one clock in every MCLK
  initial begin
    int sc = 0;
    mc_strobe = 1'b0;
    forever begin
      @(negedge clk);
      sc = (sc + 1) % MCLK;
      mc_strobe = (sc == MCLK - 1);
    end
  end

  // monitor: pops the expected phase on each change and checks its length
  initial begin
    int prev = 0;
    int dur = 0;
    @(posedge rst_n);
    forever begin
      int ph;
      @(negedge clk);
      ph = phase_of();
      if (ph != prev) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected phase change", ph, prev);
        end else begin
          chk("R3/R7 phase order", ph, exp_q.pop_front());
        end
        if (prev == 1) chk("R3 reset phase length", dur, 2 * MCLK);
        if (prev == 3) chk("R7 settle phase length", dur, STAB * MCLK);
        if (ph == 1) chk("R3 oscillators on in reset", {main_osc_en, rc_osc_en, wdt_stop}, 3'b111);
        if (ph == 2) chk("R4 power-down outputs",
                         {main_osc_en, rc_osc_en, pad_float, core_rst, wdt_stop, wdt_clr}, 6'b001110);
        if (ph == 3) chk("R7 wake outputs",
                         {main_osc_en, rc_osc_en, pad_float, wdt_stop}, 4'b1101);
        if (ph == 0) chk("R7 release", {wdt_stop, main_osc_en, rc_osc_en}, 3'b011);
        dur = 0;
        prev = ph;
      end
      dur++;
    end
  end

  task automatic wait_drained();
    int n = 0;
    while ((exp_q.size() != 0 || phase_of() != 0) && n < 400) begin
      tick();
      n++;
    end
    chk("R7 returned to run", exp_q.size(), 0);
  endtask

  task automatic powerdown(input logic sw, input int hold);
    int n = 0;
    sw_save_en = sw;
    exp_q.push_back(1);
    exp_q.push_back(2);
    pd_req_n = 1'b0;
    while (!pd_status && n < 200) begin
      tick();
      n++;
    end
    chk(sw ? "R6 entry with sw_save_en=1" : "R4 entry with sw_save_en=0", pd_status, 1);
    repeat (hold) tick();
    chk("R4 still down", {pd_status, main_osc_en, rc_osc_en}, 3'b100);
    exp_q.push_back(3);
    exp_q.push_back(0);
    pd_req_n = 1'b1;
    wait_drained();
  endtask

  initial begin
    rst_n = 1'b0; pd_req_n = 1'b1; osc_wd_en = 1'b1; sw_save_en = 1'b0;
    repeat (4) tick();
    chk("R1 reset outputs",
        {core_rst, wdt_stop, wdt_clr, main_osc_en, rc_osc_en, pad_float, pd_status}, 7'b0001100);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 after release",
        {core_rst, wdt_stop, wdt_clr, main_osc_en, rc_osc_en, pad_float, pd_status}, 7'b0001100);

    powerdown(1'b0, 20);
    powerdown(1'b1, 9);

    // R5: request with oscillator watchdog disabled
    osc_wd_en = 1'b0;
    pd_req_n = 1'b0;
    repeat (6 * MCLK) tick();
    chk("R5 ignored without osc_wd_en", {core_rst, main_osc_en, pd_status}, 3'b010);
    pd_req_n = 1'b1;
    repeat (4) tick();
    osc_wd_en = 1'b1;
    repeat (4) tick();

    // R2: single-clock glitch placed between strobes
    while (!mc_strobe) tick();
    pd_req_n = 1'b0;
    tick();
    pd_req_n = 1'b1;
    repeat (3 * MCLK) tick();
    chk("R2 glitch between strobes ignored", {core_rst, pd_status}, 2'b00);

    // R8: request withdrawn as soon as the reset phase begins
    begin
      int n = 0;
      exp_q.push_back(1);
      exp_q.push_back(2);
      exp_q.push_back(3);
      exp_q.push_back(0);
      pd_req_n = 1'b0;
      while (!core_rst && n < 100) begin
        tick();
        n++;
      end
      pd_req_n = 1'b1;
      chk("R8 reset phase started", wdt_clr, 1);
      wait_drained();
    end

    repeat (8) tick();
    chk("R6 queue empty at end", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end
endmodule